// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block sits between a timer's compare logic and one general-purpose I/O bit, and decides what that bit's pin shows. It holds an output-compare level flip-flop. A 2-bit output mode field selects the action that a compare match applies to that flip-flop: hold, toggle, clear or set. When the active mode is nonzero, the flip-flop's level replaces the port data bit on the pin. Only the non-PWM behaviour is covered, which is the free-running and clear-on-compare style of operation.

Software writes the mode into a shadow register. The shadow value becomes active, and its action is applied, only at the next single-cycle compare-match strobe or at a force strobe. A force strobe applies the shadow action at once. It raises no match event. The pin's output enable always comes from the port's direction bit. Software can therefore preload the flip-flop while the pin is still an input, and the first driven level is then known. The interface is made of plain control pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `cmp_pin_unit`

## Requirements
- R1: After reset the flip-flop level is 0, both mode registers hold 00, and the port data and direction bits are 0, so pin_oe = 0 and pin_out = 0.
- R2: pin_oe always equals the direction bit, which is loaded by ddr_wr_en on the next clock edge. This holds whatever the mode is.
- R3: When the active mode is nonzero, pin_out equals the flip-flop level. When the active mode is 00, pin_out equals the port data bit.
- R4: A mode write alone changes neither the flip-flop level nor the active mode, so it does not change pin_out. Without a match or force strobe, the flip-flop level holds.
- R5: On a match strobe, the shadow value held before that edge is copied to the active mode and applied in the same cycle. The encodings are 00 = hold, 01 = toggle, 10 = clear to 0, and 11 = set to 1. A write in that same cycle affects only the following match.
- R6: A force strobe applies the shadow action to the flip-flop on the next edge and also makes the shadow mode active.
- R7: When a match strobe and a force strobe arrive in the same cycle, the action is applied exactly once. In toggle mode the level therefore inverts a single time.
- R8: The flip-flop can be loaded while pin_oe = 0. Once the direction bit is set, the pin drives that preloaded level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Write strobe for the shadow mode register |
| mode_wr_data | input | 2 | Mode value to write |
| port_wr_en | input | 1 | Write strobe for the port data bit |
| port_wr_data | input | 1 | Port data value |
| ddr_wr_en | input | 1 | Write strobe for the direction bit |
| ddr_wr_data | input | 1 | Direction value (1 = output) |
| match_i | input | 1 | Single-cycle compare-match strobe |
| force_i | input | 1 | Force strobe |
| oc_level | output | 1 | Current output-compare flip-flop level |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The checker tests on every cycle that the output enable tracks each direction write, that the level stays put when no strobe is present, and that the clear and toggle actions come from the shadow value. It also checks that a force makes the shadow mode active and that a nonzero active mode routes the level to the pin. Other behaviours need a sequence of writes and strobes, and only the bench scenarios can show them. These are: the deferral of a mode write until the next match, a write landing in the same cycle as a match, the single application when both strobes coincide, and preloading the level before the pin is enabled. The bench sweeps every mode against both starting levels and all three strobe combinations.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OCM_HOLD   = 2'b00,
    OCM_TOGGLE = 2'b01,
    OCM_CLEAR  = 2'b10,
    OCM_SET    = 2'b11
  } ocm_e;

  function automatic logic ocm_apply(input ocm_e mode, input logic cur);
    unique case (mode)
      OCM_TOGGLE: ocm_apply = ~cur;
      OCM_CLEAR:  ocm_apply = 1'b0;
      OCM_SET:    ocm_apply = 1'b1;
      default:    ocm_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_mode_regs.sv
module cmp_mode_regs
  import cmp_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              apply,
  output ocm_e              shadow,
  output ocm_e              active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= OCM_HOLD;
      active <= OCM_HOLD;
    end else begin
      if (wr_en) shadow <= ocm_e'(wr_data);
      if (apply) active <= shadow;
    end
  end
endmodule

// File: rtl/cmp_oc_ff.sv
module cmp_oc_ff
  import cmp_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic apply,
  input  ocm_e mode,
  output logic level
);
  logic level_nxt;

  always_comb begin
    level_nxt = level;
    if (apply) level_nxt = ocm_apply(mode, level);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level_nxt;
  end
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
  import cmp_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_wr_en,
  input  logic port_wr_data,
  input  logic ddr_wr_en,
  input  logic ddr_wr_data,
  input  ocm_e active,
  input  logic oc_level,
  output logic pin_out,
  output logic pin_oe
);
  logic port_q;
  logic ddr_q;
  logic override;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= 1'b0;
      ddr_q  <= 1'b0;
    end else begin
      if (port_wr_en) port_q <= port_wr_data;
      if (ddr_wr_en)  ddr_q  <= ddr_wr_data;
    end
  end

  always_comb begin
    override = |active;
    pin_out  = override ? oc_level : port_q;
    pin_oe   = ddr_q;
  end
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic [MODE_W-1:0] mode_wr_data,
  input  logic              port_wr_en,
  input  logic              port_wr_data,
  input  logic              ddr_wr_en,
  input  logic              ddr_wr_data,
  input  logic              match_i,
  input  logic              force_i,
  output logic              oc_level,
  output logic              pin_out,
  output logic              pin_oe
);
  ocm_e shadow_mode;
  ocm_e act_mode;
  logic apply_evt;

  // One application per cycle, whether match, force or both.
  assign apply_evt = match_i | force_i;

  cmp_mode_regs u_modes (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .apply   (apply_evt),
    .shadow  (shadow_mode),
    .active  (act_mode)
  );

  // The action uses the value being copied in, i.e. the shadow.
  cmp_oc_ff u_ocff (
    .clk   (clk),
    .rst_n (rst_n),
    .apply (apply_evt),
    .mode  (shadow_mode),
    .level (oc_level)
  );

  cmp_pin_mux u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_wr_en   (port_wr_en),
    .port_wr_data (port_wr_data),
    .ddr_wr_en    (ddr_wr_en),
    .ddr_wr_data  (ddr_wr_data),
    .active       (act_mode),
    .oc_level     (oc_level),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );
endmodule

// File: rtl/cmp_pin_unit_chk.sv
module cmp_pin_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ddr_wr_en,
  input logic       ddr_wr_data,
  input logic       match_i,
  input logic       force_i,
  input logic       oc_level,
  input logic       pin_out,
  input logic       pin_oe,
  input logic [1:0] shadow_mode,
  input logic [1:0] act_mode
);
  assert_oe_follows_ddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_wr_en |=> pin_oe == $past(ddr_wr_data));

  assert_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode != 2'b00) |-> pin_out == oc_level);

  assert_level_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_i && !force_i) |=> $stable(oc_level));

  assert_clear_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_i || force_i) && shadow_mode == 2'b10) |=> !oc_level);

  assert_force_activates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> act_mode == $past(shadow_mode));

  assert_single_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_i || force_i) && shadow_mode == 2'b01) |=> oc_level != $past(oc_level));
endmodule

bind cmp_pin_unit cmp_pin_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ddr_wr_en   (ddr_wr_en),
  .ddr_wr_data (ddr_wr_data),
  .match_i     (match_i),
  .force_i     (force_i),
  .oc_level    (oc_level),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .shadow_mode (shadow_mode),
  .act_mode    (act_mode)
);

// File: tb/cmp_pin_unit_bench.sv
`timescale 1ns/1ps
module cmp_pin_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr_en = 1'b0;
  logic [1:0] mode_wr_data = 2'b00;
  logic port_wr_en = 1'b0, port_wr_data = 1'b0;
  logic ddr_wr_en = 1'b0, ddr_wr_data = 1'b0;
  logic match_i = 1'b0, force_i = 1'b0;
  logic oc_level, pin_out, pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_pin_unit u_cmp_pin_unit (
    .clk(clk), .rst_n(rst_n),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
    .ddr_wr_en(ddr_wr_en), .ddr_wr_data(ddr_wr_data),
    .match_i(match_i), .force_i(force_i),
    .oc_level(oc_level), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic model(input logic [1:0] m, input logic cur);
    case (m)
      2'b01:   model = ~cur;
      2'b10:   model = 1'b0;
      2'b11:   model = 1'b1;
      default: model = cur;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge later, sample at the next negedge.
  task automatic tick();
    @(negedge clk);
    mode_wr_en = 0; port_wr_en = 0; ddr_wr_en = 0; match_i = 0; force_i = 0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr_en = 1; mode_wr_data = m; tick();
  endtask

  task automatic wr_port(input logic p);
    port_wr_en = 1; port_wr_data = p; tick();
  endtask

  task automatic wr_ddr(input logic d);
    ddr_wr_en = 1; ddr_wr_data = d; tick();
  endtask

  task automatic do_force();
    force_i = 1; tick();
  endtask

  task automatic do_match();
    match_i = 1; tick();
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic exp;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    check("R1 oc_level", oc_level, 1'b0);
    check("R1 pin_oe", pin_oe, 1'b0);
    check("R1 pin_out", pin_out, 1'b0);

    // R2/R3: with mode 00 the pin follows the port bit, enable follows direction
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        wr_port(p[0]); wr_ddr(d[0]);
        check("R3 port passthrough", pin_out, p[0]);
        check("R2 oe", pin_oe, d[0]);
      end
    end

    wr_port(1'b1);
    // Sweep: mode x starting level x event (0 match, 1 force, 2 both)
    for (int m = 0; m < 4; m++) begin
      for (int init = 0; init < 2; init++) begin
        for (int ev = 0; ev < 3; ev++) begin
          wr_mode(init[0] ? 2'b11 : 2'b10);
          do_force();
          check("R6 preset level", oc_level, init[0]);
          wr_mode(m[1:0]);
          // R4: a write alone changes nothing visible
          check("R4 level after write", oc_level, init[0]);
          check("R4 pin after write", pin_out, init[0]);
          match_i = (ev != 1); force_i = (ev != 0); tick();
          exp = model(m[1:0], init[0]);
          if (ev == 0)      check("R5 match action", oc_level, exp);
          else if (ev == 1) check("R6 force action", oc_level, exp);
          else              check("R7 combined action", oc_level, exp);
          check("R3 pin select", pin_out, (m != 0) ? exp : 1'b1);
        end
      end
    end

    // R5: write in the match cycle applies only at the next match
    wr_mode(2'b10); do_force();
    mode_wr_en = 1; mode_wr_data = 2'b11; match_i = 1; tick();
    check("R5 write during match uses old shadow", oc_level, 1'b0);
    do_match();
    check("R5 next match uses new value", oc_level, 1'b1);

    // R8: preload while pin is an input
    wr_ddr(1'b0); wr_mode(2'b10); do_force();
    wr_mode(2'b11); do_force();
    check("R8 oe off while preloaded", pin_oe, 1'b0);
    check("R8 level preloaded", oc_level, 1'b1);
    wr_ddr(1'b1);
    check("R8 oe on", pin_oe, 1'b1);
    check("R8 preloaded level drives pin", pin_out, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule